// File: doc/BRIEF.md
# Maskable Edge-Selectable Interrupt Register

This block collects hardware events into a word of status bits and turns them into two qualified outputs: an interrupt and a halt request. Each bit has a fixed capture rule chosen when the block is built. The rule is one of four: follow the level, catch a low-to-high transition, catch a high-to-low transition, or catch any change. Transitions are found by comparing the input with a copy of it registered one clock earlier.

When the sticky option is on, a captured bit stays set until software clears it. Software clears a bit by writing a one to it in the status word, or by reading the read-and-clear alias, which clears every bit it returns. When the sticky option is off, each status bit shows the event detector's output from the previous clock and is never latched. The interrupt output is registered. It is high when any status bit is set, its enable bit is one and its mask bit is zero. The halt output follows the same rule with a separate enable and mask pair.

Software reaches the block through a simple single-cycle register port. The word offsets are: status at 0x00 (write one to clear), interrupt enable at 0x04, interrupt mask at 0x08, halt enable at 0x0C, halt mask at 0x10, and the read-and-clear alias of status at 0x14. All registers reset to zero.

Top module: `irq_edge_reg`

## Requirements
- R1: After reset, every register reads zero and both `irq_o` and `halt_o` are low.
- R2: A bit in level mode (mode code 00) is set in status at each clock edge where its input is high.
- R3: A bit in rising mode (mode code 01) is set at a clock edge where its input is high and was low at the previous edge.
- R4: A bit in falling mode (mode code 10) is set at a clock edge where its input is low and was high at the previous edge.
- R5: A bit in either-edge mode (mode code 11) is set at a clock edge where its input differs from its value at the previous edge.
- R6: With the sticky option on, a status bit stays set until a write to offset 0x00 carries a one in that bit position. Bits written with zero keep their value.
- R7: A read at offset 0x14 returns the current status and clears all status bits at the clock edge that ends the read.
- R8: If a new event and a software clear reach the same bit at the same edge, the bit ends up set.
- R9: With the sticky option off, each status bit equals the event detector's output from the previous edge, and software clears have no lasting effect.
- R10: `irq_o` goes high one clock after some status bit is set with its enable bit (0x04) at one and its mask bit (0x08) at zero. Otherwise `irq_o` is low.
- R11: `halt_o` follows the rule of R10, using halt enable (0x0C) and halt mask (0x10) in place of the interrupt pair.
- R12: Offsets 0x04 to 0x10 read back the last value written. Reads at unmapped offsets return zero, and read data is zero when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_src_i | input | WIDTH | Hardware event inputs, one per status bit |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational |
| irq_o | output | 1 | Registered interrupt request |
| halt_o | output | 1 | Registered halt request |

## Verification
Event capture and software clearing can hit the same status bit at the same clock edge. The bench provokes this by holding a level-mode input high during the cycle that writes one to that bit. It then reads status in the next cycle and expects the bit to be set, which shows the event won. It also clears bits by writing one to them and by reading the clear alias while other inputs stay quiet or change. A behavioural model runs alongside and checks read data, `irq_o` and `halt_o` on every clock, for a sticky instance and a non-sticky instance.

// File: rtl/irq_edge_reg.sv
module irq_edge_reg #(
  parameter int WIDTH = 32,
  parameter int ADDR_W = 8,
  parameter logic [2*WIDTH-1:0] MODE_MAP = '0,
  parameter bit STICKY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  evt_src_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              halt_o
);
  localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_EN    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_HEN   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_HMASK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_RCLR  = ADDR_W'(8'h14);

  logic [WIDTH-1:0] src_q, evt, status_q, en_q, mask_q, hen_q, hmask_q, clr;
  logic wr, rd;

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  for (genvar i = 0; i < WIDTH; i++) begin : g_det
    always_comb begin
      unique case (MODE_MAP[2*i +: 2])
        2'b00: evt[i] = evt_src_i[i];
        2'b01: evt[i] = evt_src_i[i] && !src_q[i];
        2'b10: evt[i] = !evt_src_i[i] && src_q[i];
        default: evt[i] = evt_src_i[i] ^ src_q[i];
      endcase
    end
  end

  always_comb begin
    clr = '0;
    if (wr && bus_addr == OFF_STAT) clr = bus_wdata;
    else if (rd && bus_addr == OFF_RCLR) clr = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      status_q <= '0;
      en_q     <= '0;
      mask_q   <= '0;
      hen_q    <= '0;
      hmask_q  <= '0;
      irq_o    <= 1'b0;
      halt_o   <= 1'b0;
    end else begin
      src_q    <= evt_src_i;
      status_q <= STICKY ? ((status_q & ~clr) | evt) : evt;
      irq_o    <= |(status_q & en_q & ~mask_q);
      halt_o   <= |(status_q & hen_q & ~hmask_q);
      if (wr && bus_addr == OFF_EN)    en_q    <= bus_wdata;
      if (wr && bus_addr == OFF_MASK)  mask_q  <= bus_wdata;
      if (wr && bus_addr == OFF_HEN)   hen_q   <= bus_wdata;
      if (wr && bus_addr == OFF_HMASK) hmask_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        OFF_STAT, OFF_RCLR: bus_rdata = status_q;
        OFF_EN:             bus_rdata = en_q;
        OFF_MASK:           bus_rdata = mask_q;
        OFF_HEN:            bus_rdata = hen_q;
        OFF_HMASK:          bus_rdata = hmask_q;
        default:            bus_rdata = '0;
      endcase
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (STICKY && !(wr && bus_addr == OFF_STAT) && !(rd && bus_addr == OFF_RCLR))
      |=> (($past(status_q) & ~status_q) == '0)); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    STICKY |=> (($past(evt) & ~status_q) == '0)); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(status_q & en_q))); // R10
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> $past(|(status_q & hen_q))); // R11
  AST_NO_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (bus_rdata == '0)); // R12
endmodule

// File: tb/tb_irq_edge_reg.sv
module tb_irq_edge_reg;
  localparam int W = 32;
  localparam logic [2*W-1:0] MAP = {{8{2'b11}}, {8{2'b10}}, {8{2'b01}}, {8{2'b00}}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] src = '0, wdata = '0;
  logic valid = 1'b0, write = 1'b0;
  logic [7:0] addr = '0;
  logic [W-1:0] rdata, rdata_ns;
  logic irq, halt, irq_ns, halt_ns;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_edge_reg #(.WIDTH(W), .ADDR_W(8), .MODE_MAP(MAP), .STICKY(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .evt_src_i(src), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .halt_o(halt));
  irq_edge_reg #(.WIDTH(W), .ADDR_W(8), .MODE_MAP(MAP), .STICKY(1'b0)) dut_ns (
    .clk(clk), .rst_n(rst_n), .evt_src_i(src), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_ns), .irq_o(irq_ns), .halt_o(halt_ns));

  // behavioural reference model
  logic [W-1:0] m_st, m_ns, m_prev, m_en, m_mk, m_hen, m_hmk;
  logic m_irq, m_halt, m_irq_ns, m_halt_ns;

  function automatic logic [W-1:0] events(input logic [W-1:0] s, input logic [W-1:0] p);
    logic [W-1:0] e;
    for (int i = 0; i < W; i++) begin
      case (i / 8)
        0: e[i] = s[i];
        1: e[i] = s[i] & ~p[i];
        2: e[i] = ~s[i] & p[i];
        default: e[i] = s[i] ^ p[i];
      endcase
    end
    return e;
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [W-1:0] st);
    if (!valid || write) return '0;
    case (addr)
      8'h00, 8'h14: return st;
      8'h04: return m_en;
      8'h08: return m_mk;
      8'h0C: return m_hen;
      8'h10: return m_hmk;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_ns = '0; m_prev = '0; m_en = '0; m_mk = '0; m_hen = '0; m_hmk = '0;
      m_irq = 0; m_halt = 0; m_irq_ns = 0; m_halt_ns = 0;
    end else begin
      logic [W-1:0] e, c;
      e = events(src, m_prev);
      c = '0;
      if (valid && write && addr == 8'h00) c = wdata;
      if (valid && !write && addr == 8'h14) c = '1;
      m_irq = |(m_st & m_en & ~m_mk);
      m_halt = |(m_st & m_hen & ~m_hmk);
      m_irq_ns = |(m_ns & m_en & ~m_mk);
      m_halt_ns = |(m_ns & m_hen & ~m_hmk);
      m_st = (m_st & ~c) | e;
      m_ns = e;
      m_prev = src;
      if (valid && write) begin
        if (addr == 8'h04) m_en = wdata;
        if (addr == 8'h08) m_mk = wdata;
        if (addr == 8'h0C) m_hen = wdata;
        if (addr == 8'h10) m_hmk = wdata;
      end
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      check("R10 irq", W'(irq), W'(m_irq));
      check("R11 halt", W'(halt), W'(m_halt));
      check("R12 rdata", rdata, exp_read(m_st));
      check("R9 ns rdata", rdata_ns, exp_read(m_ns));
      check("R9 ns irq", W'(irq_ns), W'(m_irq_ns));
      check("R9 ns halt", W'(halt_ns), W'(m_halt_ns));
    end
  end

  task automatic idle();
    @(negedge clk); valid = 0; write = 0; addr = '0; wdata = '0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
  endtask
  task automatic rd_chk(input logic [7:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk); valid = 1; write = 0; addr = a; wdata = '0;
    #5 check(req, rdata, exp);
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk(8'h00, '0, "R1 status");
    rd_chk(8'h04, '0, "R1 enable");
    rd_chk(8'h10, '0, "R1 halt mask");
    #1 check("R1 irq", W'(irq), '0);
    check("R1 halt", W'(halt), '0);
    // R2 level capture
    @(negedge clk); src = 32'h0000_0003; valid = 0;
    @(negedge clk); src = '0;
    rd_chk(8'h00, 32'h0000_0003, "R2");
    // R3 rising, R5 either; falling bit sees a rise only
    @(negedge clk); src = 32'h0101_0100; valid = 0;
    rd_chk(8'h00, 32'h0100_0103, "R3 R5");
    wr(8'h00, '1);
    rd_chk(8'h00, '0, "R6 full clear");
    // R4 falling, R5 either
    @(negedge clk); src = '0; valid = 0;
    rd_chk(8'h00, 32'h0101_0000, "R4 R5");
    wr(8'h00, 32'h0001_0000);
    rd_chk(8'h00, 32'h0100_0000, "R6 partial clear");
    rd_chk(8'h14, 32'h0100_0000, "R7 read returns");
    rd_chk(8'h00, '0, "R7 cleared");
    // R8 event and clear in the same cycle
    src = 32'h1; wr(8'h00, 32'h1);
    @(negedge clk); src = '0; valid = 0;
    rd_chk(8'h00, 32'h1, "R8");
    wr(8'h00, 32'h1);
    rd_chk(8'h00, '0, "R8 later clear");
    // R9 non-sticky follows
    @(negedge clk); src = 32'h2; valid = 0;
    @(negedge clk); src = '0;
    #5 check("R9 ns set", rdata_ns, '0);
    rd_chk(8'h00, 32'h2, "R6 sticky keeps");
    check("R9 ns follows", rdata_ns, '0);
    wr(8'h00, '1);
    // R10 irq timing, enable and mask
    wr(8'h04, 32'h1);
    @(negedge clk); src = 32'h1; valid = 0; write = 0;
    @(negedge clk); src = '0;
    #5 check("R10 not yet", W'(irq), '0);
    idle(); #5 check("R10 asserted", W'(irq), 32'h1);
    wr(8'h08, 32'h1);
    idle(); idle(); #5 check("R10 masked", W'(irq), '0);
    // R11 halt pair
    wr(8'h0C, 32'h1);
    idle(); idle(); #5 check("R11 asserted", W'(halt), 32'h1);
    wr(8'h10, 32'h1);
    idle(); idle(); #5 check("R11 masked", W'(halt), '0);
    // R12 readback
    wr(8'h04, 32'hA5A5_0001);
    rd_chk(8'h04, 32'hA5A5_0001, "R12 enable");
    rd_chk(8'h08, 32'h1, "R12 mask");
    rd_chk(8'h0C, 32'h1, "R12 halt enable");
    rd_chk(8'h18, '0, "R12 unmapped");
    idle(); idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule